// File: doc/BRIEF.md
# Dual-Select Sensor Serial Interface

This block is the device-side digital port of a multi-channel sensor. It has two select lines. The configuration select frames a write. While it is low, bits arrive on the data input and are taken on falling serial-clock edges. When it rises, the eight most recent bits become the control code. That code picks the measured channel (angular rate, temperature, auxiliary input 1 or auxiliary input 2), and for the rate channel it can also pick a self-test polarity.

The read select frames a conversion. Its falling edge starts a conversion of the selected channel and captures the value that a parallel sample input presents. The 14-bit result then leaves on the serial output, MSB first, from the sixth falling serial-clock edge onward. The whole frame lasts 20 serial clocks. The serial output drives zero before the data bits and is released (enable low) whenever the read select is high.

All serial inputs are brought into the system clock domain through two-flop synchronisers, and all edges are detected in that domain. The serial clock must therefore run well below the system clock.

Top module: `sensor_serial_if`

## Requirements
- R1: After reset, the selected channel is angular rate (chan_o = 0), both self-test outputs are low, dout_oe_o and dout_o are low, and result_valid_o is low.
- R2: While cfg_sel_i is low, each falling edge of sclk_i shifts din_i into an 8-bit shift register, the first bit sent ending up in the MSB. When cfg_sel_i rises, the last eight bits shifted are taken as the control code and any earlier bits are discarded.
- R3: Code 0x20 selects rate (chan_o = 0), 0x10 selects temperature (chan_o = 1), 0x40 selects auxiliary 1 (chan_o = 2) and 0x80 selects auxiliary 2 (chan_o = 3). Code 0x22 selects rate with st_pos_o high, and 0x21 selects rate with st_neg_o high. Every other code leaves both self-test outputs low.
- R4: A code outside the six listed in R3 is ignored, and chan_o, st_pos_o and st_neg_o keep their previous values.
- R5: Falling sclk_i edges while cfg_sel_i is high do not shift. Shifted bits persist across write transactions, so a short write combines with bits from the previous write.
- R6: A falling edge of rd_sel_i pulses conv_start_o for one cycle and captures sample_i. Changes to sample_i later in the frame do not affect the transmitted or latched result.
- R7: During a frame, dout_oe_o is high. dout_o is 0 after falling sclk_i edges 1 to 5. After falling edge k (6 ≤ k ≤ 19) it carries result bit 19−k, so D13 is sent first and D0 last. After the 20th edge it is 0.
- R8: While rd_sel_i is high, dout_oe_o and dout_o are low. dout_oe_o drops in the system clock in which the rise of the synchronised rd_sel_i is detected.
- R9: On the 20th falling sclk_i edge of a frame, result_o is loaded with the captured sample and result_valid_o pulses for one cycle.
- R10: A frame ended by rd_sel_i rising before the 20th falling edge produces no result_valid_o pulse and leaves result_o unchanged.
- R11: Samples are carried as offset binary without change. Code 8192 (zero rate) is sent as a single 1 in the MSB followed by thirteen zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, idle low |
| din_i | input | 1 | Serial configuration data |
| cfg_sel_i | input | 1 | Configuration select, active low |
| rd_sel_i | input | 1 | Read select, active low |
| sample_i | input | 14 | Parallel sample of the selected channel from the converter model |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for dout_o (low means high impedance) |
| conv_start_o | output | 1 | One-cycle pulse at the start of a conversion |
| result_o | output | 14 | Last result of a complete frame |
| result_valid_o | output | 1 | One-cycle pulse when result_o is updated |
| chan_o | output | 2 | Selected channel: 0 rate, 1 temperature, 2 aux 1, 3 aux 2 |
| st_pos_o | output | 1 | Positive self-test request |
| st_neg_o | output | 1 | Negative self-test request |

## Verification
The bench uses the default parameters: a 14-bit sample, a 20-clock frame, data from the sixth edge and two synchroniser stages. Each serial-clock half period lasts eight system clocks, so the synchronisers and edge detectors settle between edges, and every output bit can be sampled at a known cycle after its edge. This makes it possible to check every bit position of a frame, the abort of a frame at the boundary before the 20th edge, and mixed short and long configuration writes that depend on the shift register keeping its bits between writes.

// File: rtl/sensor_serial_pkg.sv
package sensor_serial_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    CH_RATE = 2'd0,
    CH_TEMP = 2'd1,
    CH_AUX1 = 2'd2,
    CH_AUX2 = 2'd3
  } chan_e;

  localparam logic [CODE_W-1:0] CODE_RATE    = 8'h20;
  localparam logic [CODE_W-1:0] CODE_TEMP    = 8'h10;
  localparam logic [CODE_W-1:0] CODE_AUX1    = 8'h40;
  localparam logic [CODE_W-1:0] CODE_AUX2    = 8'h80;
  localparam logic [CODE_W-1:0] CODE_RATE_SP = 8'h22;
  localparam logic [CODE_W-1:0] CODE_RATE_SN = 8'h21;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[gs] <= RST_VAL;
          else     stage_q[gs] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gs] <= RST_VAL;
          else     stage_q[gs] <= stage_q[gs-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssi_cfg_path.sv
module ssi_cfg_path
  import sensor_serial_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  sclk_s,
  input  logic  cfg_sel_s,
  input  logic  din_s,
  output chan_e chan_o,
  output logic  st_pos_o,
  output logic  st_neg_o
);
  logic              sclk_q, cfg_q;
  logic              sclk_fall, cfg_rise;
  logic [CODE_W-1:0] shift_q;
  logic              code_ok;
  chan_e             chan_d, chan_q;
  logic              stp_d, stn_d, stp_q, stn_q;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign cfg_rise  = ~cfg_q & cfg_sel_s;

  always_comb begin
    code_ok = 1'b1;
    chan_d  = CH_RATE;
    stp_d   = 1'b0;
    stn_d   = 1'b0;
    case (shift_q)
      CODE_RATE:    chan_d = CH_RATE;
      CODE_TEMP:    chan_d = CH_TEMP;
      CODE_AUX1:    chan_d = CH_AUX1;
      CODE_AUX2:    chan_d = CH_AUX2;
      CODE_RATE_SP: stp_d  = 1'b1;
      CODE_RATE_SN: stn_d  = 1'b1;
      default:      code_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cfg_q   <= 1'b1;
      shift_q <= '0;
      chan_q  <= CH_RATE;
      stp_q   <= 1'b0;
      stn_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cfg_q  <= cfg_sel_s;
      if (sclk_fall && !cfg_sel_s)
        shift_q <= {shift_q[CODE_W-2:0], din_s};
      if (cfg_rise && code_ok) begin
        chan_q <= chan_d;
        stp_q  <= stp_d;
        stn_q  <= stn_d;
      end
    end
  end

  assign chan_o   = chan_q;
  assign st_pos_o = stp_q;
  assign st_neg_o = stn_q;

  AST_ST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(stp_q && stn_q)); // R3
  AST_ST_ONLY_RATE: assert property (@(posedge clk) disable iff (rst)
    (stp_q || stn_q) |-> (chan_q == CH_RATE)); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_rise |=> ($stable(chan_q) && $stable(stp_q) && $stable(stn_q))); // R4
  AST_NO_SHIFT_DESEL: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel_s && cfg_q) |=> $stable(shift_q)); // R5
endmodule

// File: rtl/ssi_read_path.sv
module ssi_read_path #(
  parameter int DATA_W     = 14,
  parameter int FRAME_CLKS = 20,
  parameter int DATA_START = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              rd_sel_s,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              conv_start_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  localparam int CNT_W = $clog2(FRAME_CLKS + 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_CLKS);
  localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(DATA_START);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_START + DATA_W - 1);

  logic              sclk_q, rd_q;
  logic              sclk_fall, rd_fall, rd_rise;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [DATA_W-1:0] cap_q, sh_q;
  logic              dout_q, oe_q, start_q, vld_q;
  logic [DATA_W-1:0] res_q;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign rd_fall   = rd_q & ~rd_sel_s;
  assign rd_rise   = ~rd_q & rd_sel_s;
  assign cnt_nxt   = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q   <= 1'b0;
      rd_q     <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      cap_q    <= '0;
      sh_q     <= '0;
      dout_q   <= 1'b0;
      oe_q     <= 1'b0;
      start_q  <= 1'b0;
      vld_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      sclk_q  <= sclk_s;
      rd_q    <= rd_sel_s;
      start_q <= 1'b0;
      vld_q   <= 1'b0;
      if (rd_rise) begin
        active_q <= 1'b0;
        oe_q     <= 1'b0;
        dout_q   <= 1'b0;
      end else if (rd_fall) begin
        active_q <= 1'b1;
        oe_q     <= 1'b1;
        dout_q   <= 1'b0;
        cnt_q    <= '0;
        cap_q    <= sample_i;
        sh_q     <= sample_i;
        start_q  <= 1'b1;
      end else if (active_q && sclk_fall && cnt_q != FRAME_CNT) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt >= FIRST_BIT && cnt_nxt <= LAST_BIT) begin
          dout_q <= sh_q[DATA_W-1];
          sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        end else begin
          dout_q <= 1'b0;
        end
        if (cnt_nxt == FRAME_CNT) begin
          res_q <= cap_q;
          vld_q <= 1'b1;
        end
      end
    end
  end

  assign dout_o         = dout_q;
  assign dout_oe_o      = oe_q;
  assign conv_start_o   = start_q;
  assign result_o       = res_q;
  assign result_valid_o = vld_q;

  AST_OE_DROP: assert property (@(posedge clk) disable iff (rst)
    rd_rise |=> !oe_q); // R8
  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !oe_q |-> !dout_q); // R8
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    start_q |-> (oe_q && !dout_q)); // R7
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (oe_q && !start_q)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> $stable(res_q)); // R10
endmodule

// File: rtl/sensor_serial_if.sv
module sensor_serial_if
  import sensor_serial_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int FRAME_CLKS  = 20,
  parameter int DATA_START  = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              cfg_sel_i,
  input  logic              rd_sel_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              conv_start_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [1:0]        chan_o,
  output logic              st_pos_o,
  output logic              st_neg_o
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_DIN  = 1;
  localparam int IDX_CFG  = 2;
  localparam int IDX_RD   = 3;
  localparam int N_SYNC   = 4;

  logic [N_SYNC-1:0] raw_in, syn_in;
  chan_e             chan_w;

  assign raw_in[IDX_SCLK] = sclk_i;
  assign raw_in[IDX_DIN]  = din_i;
  assign raw_in[IDX_CFG]  = cfg_sel_i;
  assign raw_in[IDX_RD]   = rd_sel_i;

  ssi_sync #(
    .W       (N_SYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b1100)
  ) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  ssi_cfg_path cfg_i (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (syn_in[IDX_SCLK]),
    .cfg_sel_s (syn_in[IDX_CFG]),
    .din_s     (syn_in[IDX_DIN]),
    .chan_o    (chan_w),
    .st_pos_o  (st_pos_o),
    .st_neg_o  (st_neg_o)
  );

  ssi_read_path #(
    .DATA_W     (DATA_W),
    .FRAME_CLKS (FRAME_CLKS),
    .DATA_START (DATA_START)
  ) rd_i (
    .clk            (clk),
    .rst            (rst),
    .sclk_s         (syn_in[IDX_SCLK]),
    .rd_sel_s       (syn_in[IDX_RD]),
    .sample_i       (sample_i),
    .dout_o         (dout_o),
    .dout_oe_o      (dout_oe_o),
    .conv_start_o   (conv_start_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
  );

  assign chan_o = chan_w;
endmodule

// File: tb/sensor_serial_if_tb_top.sv
module sensor_serial_if_tb_top;
  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, din = 1'b0, cfg_sel = 1'b1, rd_sel = 1'b1;
  logic [W-1:0] sample;
  logic         dout, oe, cstart, rvalid, stp, stn;
  logic [W-1:0] result;
  logic [1:0]   chan;

  int tests = 0, fails = 0, vcnt = 0, scnt = 0;
  logic [W-1:0] base [4];
  logic [W-1:0] bias = '0;
  logic [1:0]   e_chan = 2'd0;
  logic         e_p = 1'b0, e_n = 1'b0;

  always #4 clk = ~clk;

  sensor_serial_if dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .din_i(din), .cfg_sel_i(cfg_sel),
    .rd_sel_i(rd_sel), .sample_i(sample), .dout_o(dout), .dout_oe_o(oe),
    .conv_start_o(cstart), .result_o(result), .result_valid_o(rvalid),
    .chan_o(chan), .st_pos_o(stp), .st_neg_o(stn)
  );

  function automatic logic [W-1:0] stub_val(logic [1:0] c, logic p, logic n, logic [W-1:0] b);
    logic [W-1:0] v;
    v = base[c] + b;
    if (p) v = v + W'(6226);
    if (n) v = v - W'(6226);
    return v;
  endfunction

  always_comb sample = stub_val(chan, stp, stn, bias);

  always @(posedge clk) begin
    if (rvalid) vcnt <= vcnt + 1;
    if (cstart) scnt <= scnt + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void model_code(input logic [7:0] c);
    case (c)
      8'h20: begin e_chan = 2'd0; e_p = 0; e_n = 0; end
      8'h10: begin e_chan = 2'd1; e_p = 0; e_n = 0; end
      8'h40: begin e_chan = 2'd2; e_p = 0; e_n = 0; end
      8'h80: begin e_chan = 2'd3; e_p = 0; e_n = 0; end
      8'h22: begin e_chan = 2'd0; e_p = 1; e_n = 0; end
      8'h21: begin e_chan = 2'd0; e_p = 0; e_n = 1; end
      default: ;
    endcase
  endfunction

  task automatic cfg_bits(input logic [15:0] bits, input int n);
    cfg_sel = 1'b0;
    wclk(4);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i];
      sclk = 1'b1; wclk(8);
      sclk = 1'b0; wclk(8);
    end
    cfg_sel = 1'b1;
    wclk(6);
  endtask

  task automatic check_cfg(input string req);
    check(chan == e_chan && stp == e_p && stn == e_n, req,
          {chan, stp, stn}, {e_chan, e_p, e_n});
  endtask

  task automatic read_frame(input int nf);
    logic [W-1:0] es, r0;
    int v0, s0;
    logic eb;
    es = stub_val(e_chan, e_p, e_n, bias);
    v0 = vcnt; s0 = scnt; r0 = result;
    rd_sel = 1'b0;
    wclk(6);
    check(oe && !dout, "R7 start", {oe, dout}, 2);
    check(scnt == s0 + 1, "R6 start pulse", scnt - s0, 1);
    bias = bias + W'(3);
    din = 1'b1;
    for (int k = 1; k <= nf; k++) begin
      sclk = 1'b1; wclk(8);
      sclk = 1'b0; wclk(6);
      eb = (k >= 6 && k <= 19) ? es[19 - k] : 1'b0;
      check(oe && dout == eb, $sformatf("R7 edge %0d", k), {oe, dout}, {1'b1, eb});
      wclk(2);
    end
    din = 1'b0;
    wclk(2);
    if (nf == 20) begin
      check(vcnt == v0 + 1, "R9 valid pulse", vcnt - v0, 1);
      check(result == es, "R9 R6 result", result, es);
    end else begin
      check(vcnt == v0, "R10 no pulse", vcnt - v0, 0);
      check(result == r0, "R10 result kept", result, r0);
    end
    rd_sel = 1'b1;
    wclk(6);
    check(!oe && !dout, "R8 released", {oe, dout}, 0);
  endtask

  initial begin
    logic [7:0] codes [6];
    logic [7:0] c;
    void'($urandom(32'd1234));
    codes[0] = 8'h20; codes[1] = 8'h10; codes[2] = 8'h40;
    codes[3] = 8'h80; codes[4] = 8'h22; codes[5] = 8'h21;
    for (int i = 0; i < 4; i++) base[i] = W'($urandom);
    base[0] = W'(8192);
    wclk(5);
    rst = 1'b0;
    wclk(3);
    check(chan == 0 && !stp && !stn, "R1 cfg reset", {chan, stp, stn}, 0);
    check(!oe && !dout && !rvalid, "R1 out reset", {oe, dout, rvalid}, 0);

    // R11: zero-rate code 8192 on the rate channel, no bias
    read_frame(20);
    check(result == W'(8192), "R11 offset zero", result, 8192);

    // R2: 12 bits, last eight are 0x10
    cfg_bits(16'h0A10, 12); model_code(8'h10);
    check_cfg("R2 last eight");
    // R3 each code
    for (int i = 0; i < 6; i++) begin
      cfg_bits({8'h00, codes[i]}, 8); model_code(codes[i]);
      check_cfg("R3 decode");
    end
    // R4 invalid codes
    cfg_bits(16'h0030, 8); check_cfg("R4 ignore 0x30");
    cfg_bits(16'h0023, 8); check_cfg("R4 ignore 0x23");
    cfg_bits(16'h0000, 8); check_cfg("R4 ignore 0x00");
    // R5: 0x21, frame with din high, then four zeros -> 0x10
    cfg_bits(16'h0021, 8); model_code(8'h21); check_cfg("R5 pre");
    read_frame(20);
    cfg_bits(16'h0000, 4); model_code(8'h10);
    check_cfg("R5 persist");
    // R10 abort at edge 19 and early
    read_frame(19);
    read_frame(3);
    read_frame(20);
    // random mix
    for (int it = 0; it < 10; it++) begin
      c = codes[$urandom_range(0, 5)];
      base[$urandom_range(0, 3)] = W'($urandom);
      cfg_bits({8'h00, c}, 8); model_code(c);
      check_cfg("R3 random");
      read_frame(($urandom_range(0, 3) == 0) ? 12 : 20);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule